// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of recent virtual-to-physical page translations. It sits between a requester and a page table. On a lookup the requester presents a virtual page number and a process context identifier. If a stored entry matches both fields, the physical page number and its access rights come back combinationally in the same cycle.

If no entry matches, the block captures the request and raises a refill request toward the page table. It holds that request until the page table answers, and stalls further lookups through its ready output while it waits. An answer that carries a valid mapping is installed in an entry. An answer without a valid mapping is reported as a page fault and is not installed. The requester then repeats the lookup.

Because every entry carries its owner's context identifier, a context switch does not have to discard anything. For the cases where that is wanted, a flush command clears either every entry or only the entries of one context. New translations go into the lowest-numbered free entry. When no entry is free, a round-robin pointer chooses the entry to overwrite.

Top module: `ctx_tlb`

## Requirements
- R1: A lookup that is accepted (`lk_valid` and `lk_ready` both high) and matches a valid entry drives `lk_hit` high in that same cycle, together with that entry's `lk_ppn` and `lk_rights`.
- R2: An accepted lookup that misses sets `rf_req` high from the next cycle on. `rf_req` carries the missed page number on `rf_vpn` and the context on `rf_ctx`, and these stay high and unchanged until the cycle in which `rf_ack` is sampled high.
- R3: An entry matches only when both its page number and its context identifier equal the lookup's. The same page under another context misses.
- R4: While a refill is outstanding, `lk_ready` is low and `lk_hit` stays low, whatever is on the lookup inputs.
- R5: A refill answer with `rf_pte_valid` high is installed on the clock edge where `rf_ack` is sampled. `lk_ready` is high again in the following cycle, and a repeat of the lookup hits with the returned `rf_ppn` and `rf_rights`.
- R6: A refill answer with `rf_pte_valid` low drives `lk_fault` high in the acknowledge cycle and installs nothing, so a repeat of the lookup misses again.
- R7: A flush with `fl_all` high invalidates every entry from the next cycle on.
- R8: A flush with `fl_all` low invalidates only the entries whose context equals `fl_ctx`. Entries of other contexts keep hitting.
- R9: A new translation goes into the lowest-numbered invalid entry. When all entries are valid, the victim is chosen by a round-robin pointer. The pointer is 0 after reset and moves forward by one entry, wrapping, each time it is used.
- R10: After reset all entries are invalid, `lk_ready` is high, and `rf_req` and `lk_hit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_ctx | input | CTX_W | Context identifier of the lookup |
| lk_ready | output | 1 | Lookups accepted (low while a refill is outstanding) |
| lk_hit | output | 1 | Accepted lookup matched an entry |
| lk_ppn | output | PPN_W | Physical page number of the matching entry |
| lk_rights | output | RIGHTS_W | Access rights of the matching entry (bit 0 read, bit 1 write, bit 2 execute) |
| lk_fault | output | 1 | Refill answer had no valid mapping |
| rf_req | output | 1 | Refill request to the page table |
| rf_vpn | output | VPN_W | Page number being refilled |
| rf_ctx | output | CTX_W | Context being refilled |
| rf_ack | input | 1 | Page table answer present |
| rf_pte_valid | input | 1 | Answer carries a valid mapping |
| rf_ppn | input | PPN_W | Physical page number of the answer |
| rf_rights | input | RIGHTS_W | Access rights of the answer |
| fl_valid | input | 1 | Flush command |
| fl_all | input | 1 | Flush every entry (1) or one context (0) |
| fl_ctx | input | CTX_W | Context to flush when `fl_all` is low |

## Verification
The case that is hardest to reach from the ports is round-robin replacement. The pointer is only used once every entry is valid, so the stimulus first flushes everything and fills all sixteen entries one miss at a time. It then forces two further misses and checks which earlier pages have been evicted. Context-selective flushing is covered by installing the same page under two contexts, flushing one of them, and confirming that the other still hits and the flushed one refills.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

  // Controller phases: accepting lookups, or waiting on the page table.
  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_REFILL = 1'b1
  } tlb_state_e;

  // Bit positions inside the rights field.
  localparam int RIGHT_READ  = 0;
  localparam int RIGHT_WRITE = 1;
  localparam int RIGHT_EXEC  = 2;

endpackage

// File: rtl/ctx_tlb_array.sv
module ctx_tlb_array #(
  parameter int ENTRIES  = 16,
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 20,
  parameter int CTX_W    = 8,
  parameter int RIGHTS_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [VPN_W-1:0]             q_vpn,
  input  logic [CTX_W-1:0]             q_ctx,
  input  logic                         wr_en,
  input  logic [$clog2(ENTRIES)-1:0]   wr_idx,
  input  logic [VPN_W-1:0]             wr_vpn,
  input  logic [CTX_W-1:0]             wr_ctx,
  input  logic [PPN_W-1:0]             wr_ppn,
  input  logic [RIGHTS_W-1:0]          wr_rights,
  input  logic                         fl_en,
  input  logic                         fl_all,
  input  logic [CTX_W-1:0]             fl_ctx,
  output logic [ENTRIES-1:0]           match_o,
  output logic                         hit_o,
  output logic [PPN_W-1:0]             hit_ppn_o,
  output logic [RIGHTS_W-1:0]          hit_rights_o,
  output logic [ENTRIES-1:0]           valid_o
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic [PPN_W-1:0]    ent_ppn    [ENTRIES];
  logic [RIGHTS_W-1:0] ent_rights [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic                vld_q, vld_d;
    logic [VPN_W-1:0]    vpn_q;
    logic [CTX_W-1:0]    ctx_q;
    logic [PPN_W-1:0]    ppn_q;
    logic [RIGHTS_W-1:0] rgt_q;
    logic                load;
    logic                drop;
    logic [CTX_W-1:0]    ctx_eff;

    assign load    = wr_en && (wr_idx == IDX_W'(e));
    // A flush sees the entry as it stands after a same-cycle install.
    assign ctx_eff = load ? wr_ctx : ctx_q;
    assign drop    = fl_en && (fl_all || (ctx_eff == fl_ctx));

    always_comb begin
      vld_d = (vld_q || load) && !drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
      end
    end

    // Payload needs no reset: it is qualified by the valid bit.
    always_ff @(posedge clk) begin
      if (load) begin
        vpn_q <= wr_vpn;
        ctx_q <= wr_ctx;
        ppn_q <= wr_ppn;
        rgt_q <= wr_rights;
      end
    end

    assign match_o[e]    = vld_q && (vpn_q == q_vpn) && (ctx_q == q_ctx);
    assign valid_o[e]    = vld_q;
    assign ent_ppn[e]    = ppn_q;
    assign ent_rights[e] = rgt_q;
  end

  always_comb begin
    hit_ppn_o    = '0;
    hit_rights_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match_o[e]) begin
        hit_ppn_o    = hit_ppn_o | ent_ppn[e];
        hit_rights_o = hit_rights_o | ent_rights[e];
      end
    end
  end

  assign hit_o = |match_o;

  // R3: a page/context pair never lives in two entries at once.
  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_o));

  // R7: a global flush leaves nothing valid.
  assert_flush_all_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && fl_all) |=> (valid_o == '0));

endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
  parameter int ENTRIES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ENTRIES-1:0]         valid_i,
  input  logic                       take_i,
  output logic [$clog2(ENTRIES)-1:0] victim_o,
  output logic                       full_o
);

  localparam int                   IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0]     LAST  = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx;

  // Lowest-numbered invalid entry; scanned downward so the lowest wins.
  always_comb begin
    free_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!valid_i[e]) begin
        free_idx = IDX_W'(e);
      end
    end
  end

  assign full_o   = &valid_i;
  assign victim_o = full_o ? rr_q : free_idx;

  always_comb begin
    rr_d = rr_q;
    if (take_i && full_o) begin
      rr_d = (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else begin
      rr_q <= rr_d;
    end
  end

  // R9: while a free slot exists, the chosen victim is one of them.
  assert_victim_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !full_o |-> !valid_i[victim_o]);

endmodule

// File: rtl/ctx_tlb_ctrl.sv
module ctx_tlb_ctrl
  import ctx_tlb_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [CTX_W-1:0] lk_ctx,
  input  logic             arr_hit,
  input  logic             rf_ack,
  input  logic             rf_pte_valid,
  output logic             lk_ready,
  output logic             rf_req,
  output logic [VPN_W-1:0] rf_vpn,
  output logic [CTX_W-1:0] rf_ctx,
  output logic             install_o,
  output logic             fault_o
);

  tlb_state_e       state_q, state_d;
  logic [VPN_W-1:0] vpn_q;
  logic [CTX_W-1:0] ctx_q;
  logic             miss;
  logic             answer;

  assign lk_ready  = (state_q == ST_IDLE);
  assign miss      = lk_valid && lk_ready && !arr_hit;
  assign answer    = (state_q == ST_REFILL) && rf_ack;
  assign install_o = answer && rf_pte_valid;
  assign fault_o   = answer && !rf_pte_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (miss)   state_d = ST_REFILL;
      ST_REFILL: if (rf_ack) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Capture the missing request; enable is the accepted miss.
  always_ff @(posedge clk) begin
    if (miss) begin
      vpn_q <= lk_vpn;
      ctx_q <= lk_ctx;
    end
  end

  assign rf_req = (state_q == ST_REFILL);
  assign rf_vpn = vpn_q;
  assign rf_ctx = ctx_q;

  // R2: an unanswered request holds steady.
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req && !rf_ack) |=> (rf_req && $stable(rf_vpn) && $stable(rf_ctx)));

  // R2: a request only starts after a presented lookup.
  assert_req_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rf_req) |-> $past(lk_valid));

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb #(
  parameter int ENTRIES  = 16,
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 20,
  parameter int CTX_W    = 8,
  parameter int RIGHTS_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic [VPN_W-1:0]    lk_vpn,
  input  logic [CTX_W-1:0]    lk_ctx,
  output logic                lk_ready,
  output logic                lk_hit,
  output logic [PPN_W-1:0]    lk_ppn,
  output logic [RIGHTS_W-1:0] lk_rights,
  output logic                lk_fault,
  output logic                rf_req,
  output logic [VPN_W-1:0]    rf_vpn,
  output logic [CTX_W-1:0]    rf_ctx,
  input  logic                rf_ack,
  input  logic                rf_pte_valid,
  input  logic [PPN_W-1:0]    rf_ppn,
  input  logic [RIGHTS_W-1:0] rf_rights,
  input  logic                fl_valid,
  input  logic                fl_all,
  input  logic [CTX_W-1:0]    fl_ctx
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] valid_bus;
  logic               arr_hit;
  logic [IDX_W-1:0]   victim;
  logic               full;
  logic               install;

  ctx_tlb_ctrl #(
    .VPN_W (VPN_W),
    .CTX_W (CTX_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_vpn       (lk_vpn),
    .lk_ctx       (lk_ctx),
    .arr_hit      (arr_hit),
    .rf_ack       (rf_ack),
    .rf_pte_valid (rf_pte_valid),
    .lk_ready     (lk_ready),
    .rf_req       (rf_req),
    .rf_vpn       (rf_vpn),
    .rf_ctx       (rf_ctx),
    .install_o    (install),
    .fault_o      (lk_fault)
  );

  ctx_tlb_array #(
    .ENTRIES  (ENTRIES),
    .VPN_W    (VPN_W),
    .PPN_W    (PPN_W),
    .CTX_W    (CTX_W),
    .RIGHTS_W (RIGHTS_W)
  ) u_array (
    .clk          (clk),
    .rst_n        (rst_n),
    .q_vpn        (lk_vpn),
    .q_ctx        (lk_ctx),
    .wr_en        (install),
    .wr_idx       (victim),
    .wr_vpn       (rf_vpn),
    .wr_ctx       (rf_ctx),
    .wr_ppn       (rf_ppn),
    .wr_rights    (rf_rights),
    .fl_en        (fl_valid),
    .fl_all       (fl_all),
    .fl_ctx       (fl_ctx),
    .match_o      (match),
    .hit_o        (arr_hit),
    .hit_ppn_o    (lk_ppn),
    .hit_rights_o (lk_rights),
    .valid_o      (valid_bus)
  );

  ctx_tlb_victim #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_bus),
    .take_i   (install),
    .victim_o (victim),
    .full_o   (full)
  );

  assign lk_hit = lk_valid && lk_ready && arr_hit;

  // R6: a fault answer leaves the occupancy unchanged.
  assert_fault_no_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fault && !fl_valid) |=> ($countones(valid_bus) == $past($countones(valid_bus))));

  // R5: an install into a free slot raises the occupancy by exactly one.
  assert_fill_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (install && !full && !fl_valid) |=>
      ($countones(valid_bus) == $past($countones(valid_bus)) + 1));

  // R4: no hit is reported while the page table is being waited on.
  assert_no_hit_in_refill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req |-> !lk_hit);

endmodule

// File: tb/ctx_tlb_bench.sv
module ctx_tlb_bench;

  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int CTX_W = 8;
  localparam int RW    = 3;

  localparam logic [1:0] OP_LOOK = 2'd0;
  localparam logic [1:0] OP_FCTX = 2'd1;
  localparam logic [1:0] OP_FALL = 2'd2;

  // For a lookup: ppn/rgt are the expected hit data, or the refill answer on a miss.
  typedef struct packed {
    logic [1:0]       op;
    logic [CTX_W-1:0] ctx;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic [RW-1:0]    rgt;
    logic             pte_v;
    logic             exp_hit;
    logic [3:0]       req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{OP_LOOK, 8'h01, 20'h00010, 20'hAAAAA, 3'd3, 1'b1, 1'b0, 4'd2},  // R2 miss, refill
    '{OP_LOOK, 8'h01, 20'h00010, 20'hAAAAA, 3'd3, 1'b1, 1'b1, 4'd5},  // R5 installed
    '{OP_LOOK, 8'h02, 20'h00010, 20'hBBBBB, 3'd5, 1'b1, 1'b0, 4'd3},  // R3 other context
    '{OP_LOOK, 8'h01, 20'h00010, 20'hAAAAA, 3'd3, 1'b1, 1'b1, 4'd1},  // R1
    '{OP_LOOK, 8'h02, 20'h00010, 20'hBBBBB, 3'd5, 1'b1, 1'b1, 4'd3},  // R3
    '{OP_LOOK, 8'h01, 20'h00020, 20'h00000, 3'd0, 1'b0, 1'b0, 4'd6},  // R6 fault
    '{OP_LOOK, 8'h01, 20'h00020, 20'h00000, 3'd0, 1'b0, 1'b0, 4'd6},  // R6 not installed
    '{OP_FCTX, 8'h01, 20'h00000, 20'h00000, 3'd0, 1'b0, 1'b0, 4'd8},  // R8 flush ctx 1
    '{OP_LOOK, 8'h02, 20'h00010, 20'hBBBBB, 3'd5, 1'b1, 1'b1, 4'd8},  // R8 survivor
    '{OP_LOOK, 8'h01, 20'h00010, 20'hCCCCC, 3'd1, 1'b1, 1'b0, 4'd8},  // R8 flushed
    '{OP_LOOK, 8'h01, 20'h00010, 20'hCCCCC, 3'd1, 1'b1, 1'b1, 4'd5},
    '{OP_FALL, 8'h00, 20'h00000, 20'h00000, 3'd0, 1'b0, 1'b0, 4'd7},  // R7
    '{OP_LOOK, 8'h02, 20'h00010, 20'hDDDDD, 3'd7, 1'b1, 1'b0, 4'd7},  // R7 gone
    '{OP_LOOK, 8'h02, 20'h00010, 20'hDDDDD, 3'd7, 1'b1, 1'b1, 4'd1}
  };

  logic             clk;
  logic             rst_n;
  logic             lk_valid;
  logic [VPN_W-1:0] lk_vpn;
  logic [CTX_W-1:0] lk_ctx;
  logic             lk_ready;
  logic             lk_hit;
  logic [PPN_W-1:0] lk_ppn;
  logic [RW-1:0]    lk_rights;
  logic             lk_fault;
  logic             rf_req;
  logic [VPN_W-1:0] rf_vpn;
  logic [CTX_W-1:0] rf_ctx;
  logic             rf_ack;
  logic             rf_pte_valid;
  logic [PPN_W-1:0] rf_ppn;
  logic [RW-1:0]    rf_rights;
  logic             fl_valid;
  logic             fl_all;
  logic [CTX_W-1:0] fl_ctx;

  int checks;
  int failures;

  ctx_tlb u_ctx_tlb (
    .clk (clk), .rst_n (rst_n),
    .lk_valid (lk_valid), .lk_vpn (lk_vpn), .lk_ctx (lk_ctx),
    .lk_ready (lk_ready), .lk_hit (lk_hit), .lk_ppn (lk_ppn),
    .lk_rights (lk_rights), .lk_fault (lk_fault),
    .rf_req (rf_req), .rf_vpn (rf_vpn), .rf_ctx (rf_ctx),
    .rf_ack (rf_ack), .rf_pte_valid (rf_pte_valid),
    .rf_ppn (rf_ppn), .rf_rights (rf_rights),
    .fl_valid (fl_valid), .fl_all (fl_all), .fl_ctx (fl_ctx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic flush(input logic all, input logic [CTX_W-1:0] ctx);
    @(negedge clk);
    fl_valid = 1'b1; fl_all = all; fl_ctx = ctx;
    @(posedge clk); #1;
    fl_valid = 1'b0; fl_all = 1'b0;
  endtask

  task automatic access(input vec_t v);
    string rq;
    rq = $sformatf("R%0d", v.req);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v.vpn; lk_ctx = v.ctx;
    #1;
    check(lk_ready == 1'b1, rq, "ready at lookup", lk_ready, 1);
    check(lk_hit == v.exp_hit, rq, "hit", lk_hit, v.exp_hit);
    if (v.exp_hit) begin
      check(lk_ppn == v.ppn, rq, "ppn", lk_ppn, v.ppn);
      check(lk_rights == v.rgt, rq, "rights", lk_rights, v.rgt);
      @(posedge clk); #1;
      lk_valid = 1'b0;
    end else begin
      @(posedge clk); #1;
      // R2/R4: request raised one cycle later, lookups stalled.
      @(negedge clk); #1;
      check(rf_req == 1'b1, "R2", "rf_req", rf_req, 1);
      check(rf_vpn == v.vpn, "R2", "rf_vpn", rf_vpn, v.vpn);
      check(rf_ctx == v.ctx, "R2", "rf_ctx", rf_ctx, v.ctx);
      check(lk_ready == 1'b0, "R4", "ready while waiting", lk_ready, 0);
      @(negedge clk); #1;
      check(rf_req == 1'b1 && rf_vpn == v.vpn, "R2", "request held", rf_req, 1);
      check(lk_hit == 1'b0, "R4", "hit while waiting", lk_hit, 0);
      @(negedge clk);
      rf_ack = 1'b1; rf_pte_valid = v.pte_v; rf_ppn = v.ppn; rf_rights = v.rgt;
      #1;
      check(lk_fault == !v.pte_v, "R6", "fault", lk_fault, !v.pte_v);
      @(posedge clk); #1;
      rf_ack = 1'b0; rf_pte_valid = 1'b0; lk_valid = 1'b0;
      @(negedge clk); #1;
      check(lk_ready == 1'b1, "R5", "ready after answer", lk_ready, 1);
      check(rf_req == 1'b0, "R5", "request dropped", rf_req, 0);
    end
  endtask

  function automatic vec_t mk(input logic [CTX_W-1:0] c, input logic [VPN_W-1:0] a,
                              input logic [PPN_W-1:0] p, input logic pv,
                              input logic h, input logic [3:0] r);
    vec_t v;
    v.op = OP_LOOK; v.ctx = c; v.vpn = a; v.ppn = p; v.rgt = 3'd2;
    v.pte_v = pv; v.exp_hit = h; v.req = r;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0;
    lk_valid = 1'b0; lk_vpn = '0; lk_ctx = '0;
    rf_ack = 1'b0; rf_pte_valid = 1'b0; rf_ppn = '0; rf_rights = '0;
    fl_valid = 1'b0; fl_all = 1'b0; fl_ctx = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset state.
    @(negedge clk); #1;
    check(lk_ready == 1'b1, "R10", "ready", lk_ready, 1);
    check(rf_req == 1'b0, "R10", "rf_req", rf_req, 0);
    check(lk_hit == 1'b0, "R10", "hit idle", lk_hit, 0);

    foreach (VECS[i]) begin
      if (VECS[i].op == OP_LOOK) access(VECS[i]);
      else flush(VECS[i].op == OP_FALL, VECS[i].ctx);
    end

    // R9: fill every entry, then force round-robin replacement.
    flush(1'b1, '0);
    for (int i = 0; i < 16; i++) access(mk(8'h03, 20'h00100 + i, 20'h50000 + i, 1'b1, 1'b0, 4'd9));
    for (int i = 0; i < 16; i++) access(mk(8'h03, 20'h00100 + i, 20'h50000 + i, 1'b1, 1'b1, 4'd9));
    access(mk(8'h03, 20'h00200, 20'h60000, 1'b1, 1'b0, 4'd9));  // evicts entry 0 (page 0x100)
    access(mk(8'h03, 20'h00100, 20'h70000, 1'b1, 1'b0, 4'd9));  // R9 miss, evicts entry 1
    access(mk(8'h03, 20'h00102, 20'h50002, 1'b1, 1'b1, 4'd9));  // R9 untouched
    access(mk(8'h03, 20'h00101, 20'h00000, 1'b0, 1'b0, 4'd9));  // R9 evicted, answer faults
    access(mk(8'h03, 20'h00200, 20'h60000, 1'b1, 1'b1, 4'd9));
    access(mk(8'h03, 20'h00100, 20'h70000, 1'b1, 1'b1, 4'd9));

    // R9: a free slot is reused before the pointer.
    flush(1'b0, 8'h03);
    access(mk(8'h04, 20'h00300, 20'h12345, 1'b1, 1'b0, 4'd9));
    access(mk(8'h04, 20'h00300, 20'h12345, 1'b1, 1'b1, 4'd9));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule